// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses an SDRAM device walks through during a burst. The caller gives a start strobe, the starting column and a read/write flag. It also gives the mode settings: burst length code, burst ordering, and a flag that makes writes single-beat. From the clock after the strobe, the block emits one column per cycle without further addressing. For every beat it raises a valid flag, and it marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. The order within the block is either sequential or interleaved. A full-page burst walks the whole row, wraps around, and runs until it is terminated. A new strobe always takes over from a burst in progress. Strobes spaced exactly one burst length apart give an unbroken stream of beats.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `valid_o` and `last_o` are both low until a start strobe is taken.
- R2: The cycle after `start_i` is sampled high, `valid_o` is high and `col_o` equals the sampled start column. One further column follows on every clock with no more input.
- R3: `bl_sel_i` selects the burst length: code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4, 5 and 6 behave as a 1-beat burst.
- R4: With `interleave_i`=0, beat k of a fixed burst of length L from start column s is `(s & ~(L-1)) | ((s+k) & (L-1))`.
- R5: With `interleave_i`=1, beat k of a fixed burst of length L from start column s is `(s & ~(L-1)) | ((s ^ k) & (L-1))`.
- R6: A full-page burst gives column `(s+k) mod 2^COL_W` at beat k. It wraps past the row end, ignores `interleave_i`, never raises `last_o`, and runs until stopped.
- R7: `last_o` is high on exactly the final beat of a fixed burst. `valid_o` is low the next cycle unless a new strobe was taken.
- R8: With `wr_single_i`=1, a write (`is_write_i`=1) produces exactly one beat with `last_o` high, whatever the length code. Reads, and writes with `wr_single_i`=0, use the programmed length.
- R9: `stop_i` high at a clock edge during a burst ends it, and no beat appears in the next cycle. `stop_i` while idle has no effect. `start_i` has priority over `stop_i`.
- R10: A strobe during an active burst abandons it. The next cycle carries beat 0 of the new burst.
- R11: A strobe in the cycle of a burst's last beat makes the next burst's first beat follow with no idle cycle between them.
- R12: Mode inputs and the start column are sampled only with the strobe. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | COL_W | Starting column |
| is_write_i | input | 1 | 1 for a write access |
| bl_sel_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved ordering |
| wr_single_i | input | 1 | 1 makes writes single-beat |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a fixed burst |

## Verification
The bench sweeps every length code, both orderings and every start column of a 32-column row. This exposes the wrap at the aligned block edge: a design that carried into the upper bits would leave the block at unaligned starts. Full-page runs go past the row end to catch a counter that saturates or leaves the page. Write bursts with the single-write flag catch a design that ignores the access type. Reads with that flag catch one that shortens reads too. Further directed cases check three more timings. An abort mid-burst must restart on the next beat. A back-to-back strobe must leave no gap. Mode inputs changed during a burst must not alter it, which a design sampling them live would fail.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;

    typedef enum logic [2:0] {
        LEN_ONE  = 3'd0,
        LEN_TWO  = 3'd1,
        LEN_FOUR = 3'd2,
        LEN_EGHT = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    typedef struct packed {
        logic page;
        logic ilv;
        logic one;
    } burst_mode_t;

    function automatic int unsigned block_mask(logic [2:0] code, int unsigned colw);
        case (code)
            LEN_TWO:  return 32'd1;
            LEN_FOUR: return 32'd3;
            LEN_EGHT: return 32'd7;
            LEN_PAGE: return (32'd1 << colw) - 32'd1;
            default:  return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdcol_cfg_latch.sv
module sdcol_cfg_latch
    import sdcol_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] col_in,
    input  logic [2:0]       code_in,
    input  logic             ilv_in,
    input  logic             wr_in,
    input  logic             ws_in,
    output logic [COL_W-1:0] col_q,
    output logic [COL_W-1:0] mask_q,
    output logic [COL_W-1:0] len_m1_q,
    output burst_mode_t      mode_q
);
    logic [COL_W-1:0] mask_d;
    burst_mode_t      mode_d;

    always_comb begin
        mask_d      = COL_W'(block_mask(code_in, COL_W));
        mode_d.one  = wr_in && ws_in;
        mode_d.page = (code_in == LEN_PAGE) && !mode_d.one;
        mode_d.ilv  = ilv_in && !mode_d.page;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q    <= '0;
            mask_q   <= '0;
            len_m1_q <= '0;
            mode_q   <= '0;
        end else if (load) begin
            col_q    <= col_in;
            mask_q   <= mask_d;
            len_m1_q <= mode_d.one ? '0 : mask_d;
            mode_q   <= mode_d;
        end
    end
endmodule

// File: rtl/sdcol_beat_ctr.sv
module sdcol_beat_ctr #(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             stop,
    input  logic             page,
    input  logic [COL_W-1:0] len_m1,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic             final_beat
);
    assign final_beat = active && !page && (cnt == len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (stop || final_beat) active <= 1'b0;
            cnt <= cnt + COL_W'(1);
        end
    end
endmodule

// File: rtl/sdcol_addr_map.sv
module sdcol_addr_map #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] cnt,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] off;

    always_comb begin
        off = ilv ? (base_col ^ cnt) : (base_col + cnt);
        col = (base_col & ~mask) | (off & mask);
    end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdcol_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_write_i,
    input  logic [2:0]       bl_sel_i,
    input  logic             interleave_i,
    input  logic             wr_single_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] base_q, mask_q, len_m1_q, cnt;
    burst_mode_t      mode_q;
    logic             active, final_beat;

    sdcol_cfg_latch #(.COL_W(COL_W)) cfg_i (
        .clk(clk), .rst(rst), .load(start_i),
        .col_in(start_col_i), .code_in(bl_sel_i), .ilv_in(interleave_i),
        .wr_in(is_write_i), .ws_in(wr_single_i),
        .col_q(base_q), .mask_q(mask_q), .len_m1_q(len_m1_q), .mode_q(mode_q)
    );

    sdcol_beat_ctr #(.COL_W(COL_W)) ctr_i (
        .clk(clk), .rst(rst), .load(start_i), .stop(stop_i),
        .page(mode_q.page), .len_m1(len_m1_q),
        .active(active), .cnt(cnt), .final_beat(final_beat)
    );

    sdcol_addr_map #(.COL_W(COL_W)) map_i (
        .base_col(base_q), .mask(mask_q), .cnt(cnt), .ilv(mode_q.ilv), .col(col_o)
    );

    assign valid_o = active;
    assign last_o  = final_beat;

    // R1 / R7: a last marker only ever accompanies a beat
    a_r7_last_has_beat: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    a_r7_ends_after_last: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_write_i && wr_single_i) |=> last_o);

    a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !stop_i && !mode_q.ilv)
        |=> (((col_o - $past(col_o)) & mask_q) == COL_W'(1)));

    a_r5_stay_in_block: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !stop_i)
        |=> (((col_o ^ $past(col_o)) & ~mask_q) == '0));
endmodule

// File: tb/sdram_col_seq_tb_top.sv
module sdram_col_seq_tb_top;
    localparam int CW = 5;
    localparam int ROW = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_col_i = '0;
    logic          is_write_i = 1'b0;
    logic [2:0]    bl_sel_i = '0;
    logic          interleave_i = 1'b0;
    logic          wr_single_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [CW-1:0] col_o;
    logic          valid_o, last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_col_seq #(.COL_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .is_write_i(is_write_i), .bl_sel_i(bl_sel_i), .interleave_i(interleave_i),
        .wr_single_i(wr_single_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int code, input int wr, input int ws, input int run);
        if (wr != 0 && ws != 0) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return run;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int k, input int m, input int il, input int pg);
        if (pg != 0) return (s + k) % ROW;
        if (il != 0) return (s & ~m) | ((s ^ k) & m);
        return (s & ~m) | ((s + k) & m);
    endfunction

    // Issue one burst and check every beat; mode inputs are scrambled after the strobe (R12)
    task automatic run_burst(input int code, input int il, input int s,
                             input int wr, input int ws, input int run);
        int len, m, pg;
        string creq;
        len = exp_len(code, wr, ws, run);
        pg  = (code == 7 && !(wr != 0 && ws != 0)) ? 1 : 0;
        m   = (len > 1 && pg == 0) ? len - 1 : 0;
        creq = (pg != 0) ? "R6" : ((il != 0) ? "R5" : "R4");
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(s); bl_sel_i = 3'(code);
        interleave_i = il[0]; is_write_i = wr[0]; wr_single_i = ws[0];
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start_i = 1'b0;
                start_col_i = CW'(s ^ 13);
                bl_sel_i = 3'(code ^ 5);
                interleave_i = ~interleave_i;
                wr_single_i = ~wr_single_i;
            end
            check_eq("R3 valid", int'(valid_o), 1);
            check_eq(creq, int'(col_o), exp_col(s, k, m, il, pg));
            check_eq(pg != 0 ? "R6 last" : "R7 last", int'(last_o), (pg == 0 && k == len - 1) ? 1 : 0);
            if (pg != 0 && k == len - 1) stop_i = 1'b1;
        end
        @(negedge clk);
        stop_i = 1'b0;
        check_eq(pg != 0 ? "R9 stop" : "R7 end", int'(valid_o), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 valid", int'(valid_o), 0);
        check_eq("R1 last", int'(last_o), 0);

        // R9: stop while idle does nothing
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check_eq("R9 idle", int'(valid_o), 0);

        // R3 R4 R5 R6 R7: full sweep
        for (int code = 0; code < 8; code++)
            for (int il = 0; il < 2; il++)
                for (int s = 0; s < ROW; s++)
                    run_burst(code, il, s, 0, 0, ROW + 7);

        // R8: single-write shortens writes only
        for (int code = 0; code < 8; code++) begin
            run_burst(code, 0, 11, 1, 1, ROW + 3);
            run_burst(code, 1, 6, 0, 1, ROW + 3);
            run_burst(code, 0, 19, 1, 0, ROW + 3);
        end

        // R10: abort an 8-beat burst after two beats
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(5); bl_sel_i = 3'd3; interleave_i = 1'b0;
        is_write_i = 1'b0; wr_single_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check_eq("R10 pre0", int'(col_o), 5);
        @(negedge clk);
        check_eq("R10 pre1", int'(col_o), 6);
        start_i = 1'b1; start_col_i = CW'(22); bl_sel_i = 3'd2; interleave_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            check_eq("R10 valid", int'(valid_o), 1);
            check_eq("R10 col", int'(col_o), 22 ^ k);
            check_eq("R10 last", int'(last_o), k == 3 ? 1 : 0);
        end
        @(negedge clk);
        check_eq("R10 end", int'(valid_o), 0);

        // R11: back-to-back 4-beat bursts with no gap
        start_i = 1'b1; start_col_i = CW'(1); bl_sel_i = 3'd2; interleave_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            check_eq("R11 a", int'(col_o), (k + 1) % 4);
            check_eq("R11 av", int'(valid_o), 1);
            if (k == 3) begin start_i = 1'b1; start_col_i = CW'(9); end
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            check_eq("R11 b", int'(col_o), 8 + ((1 + k) % 4));
            check_eq("R11 bv", int'(valid_o), 1);
        end
        @(negedge clk);
        check_eq("R11 end", int'(valid_o), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule